// File: doc/BRIEF.md
# Clock and Reset State Controller

This block sequences a microcontroller through its power states: normal running, a low-power stop, two oscillator-stabilization waits, an operation-level reset and a settings-level reset. It drives the gates that the rest of the chip obeys: the internal clock enable, the oscillator and PLL keep-alive lines, the pin high-impedance control, the operation reset to peripherals and the CPU halt. It also holds a flag telling the CPU which restart sequence to run when it leaves reset.

The two reset levels are ordered. A settings reset request wins over everything else from every state. The settings-reset state always leads to the wait-then-reset path. An operation reset request sends the controller to the operation-reset state, and it passes through the reset-flavoured stabilization wait first if the oscillator was stopped. The stabilization timebase lives inside the block. Its wait length is picked by a 2-bit select that is captured when a wait begins.

All outputs are registered and change on the clock edge that follows the sampled input. A synchronous active-high reset places the block in the settings-reset state.

Top module: `pm_state_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the block is in the settings-reset state. In that state `clk_en`=1, `osc_en`=1, `pll_en`=`pll_on`, `pin_hiz`=0, `op_rst`=1, `cpu_halt`=1 and `restart_set`=1.
- R2: The settings-reset state is left only when `set_rst_req` is low. It then moves to the reset-flavoured wait, which shows `clk_en`=0, `osc_en`=1, `pll_en`=`pll_on`, `pin_hiz`=0, `op_rst`=1 and `cpu_halt`=1.
- R3: In either wait state the clocks stay gated for exactly 2^L+1 cycles. L is the log length picked by `wait_sel` (0..3 selects parameters WAIT_LOG0..WAIT_LOG3, which default to 10, 13, 15 and 17). `wait_sel` is captured on the edge that enters the wait, and later changes do not affect that wait.
- R4: When the reset-flavoured wait expires, the block enters the operation-reset state: `clk_en`=1, `osc_en`=1, `op_rst`=1, `cpu_halt`=1. It stays there while `op_rst_req` is high. On the first edge with `op_rst_req` low it enters run: `clk_en`=1, `op_rst`=0, `cpu_halt`=0, `pin_hiz`=0.
- R5: `restart_set` is 1 if the last path into run passed through the settings-reset state, and 0 if it did not. It is set on entry to the settings-reset state. It is cleared on entry to stop and on a direct move from run to operation reset. It does not change while in run.
- R6: `stop_req` takes effect only in run, and is ignored in every other state. Stop shows `clk_en`=0, `osc_en`=0, `pin_hiz`=1, `op_rst`=0, `cpu_halt`=1, `pll_en`=`pll_on & pll_keep`.
- R7: `wake` in stop moves to the run-flavoured wait: `clk_en`=0, `osc_en`=1, `pll_en`=`pll_on`, `pin_hiz`=0, `op_rst`=0, `cpu_halt`=1. When that wait expires, the block enters run.
- R8: `op_rst_req` in stop or in the run-flavoured wait moves to the reset-flavoured wait and restarts the count with a fresh wait length. In run it moves straight to the operation-reset state.
- R9: `set_rst_req` high moves the block to the settings-reset state on the next edge, from every state.
- R10: When several requests arrive in one cycle, they are served in this order: `set_rst_req`, then `op_rst_req`, then `stop_req`, `wake` or the wait expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock (oscillator domain) |
| rst | input | 1 | Synchronous active-high power-up reset |
| stop_req | input | 1 | Request to enter stop (honoured in run only) |
| wake | input | 1 | Wake event that leaves stop |
| op_rst_req | input | 1 | Operation-level reset request (level) |
| set_rst_req | input | 1 | Settings-level reset request (level) |
| wait_sel | input | 2 | Stabilization wait length select |
| pll_on | input | 1 | PLL enabled by configuration |
| pll_keep | input | 1 | Keep PLL running during stop |
| clk_en | output | 1 | Internal clock enable |
| osc_en | output | 1 | Oscillator keep-alive |
| pll_en | output | 1 | PLL keep-alive |
| pin_hiz | output | 1 | External pin high-impedance control |
| op_rst | output | 1 | Operation reset to internal circuits |
| cpu_halt | output | 1 | CPU halt / program counter hold |
| restart_set | output | 1 | 1: run settings restart sequence, 0: operation restart sequence |

## Verification
A wrong state shows up at the ports on the very next edge, because every state has its own pattern on the six control outputs. The only two that match are the settings-reset and operation-reset states, and they differ in where they go next: one drops `clk_en` and the other releases `op_rst`. A wrong timer limit or a select that is not captured shows up as a gated-clock stretch of the wrong length. The bench measures that length cycle by cycle for each select value. A restart flag on the wrong path can only be seen once run is entered, so every sequence ends in run and reads `restart_set` there.

// File: rtl/pm_pkg.sv
package pm_pkg;

  typedef enum logic [2:0] {
    ST_SETRST = 3'd0,
    ST_WAITR  = 3'd1,
    ST_OPRST  = 3'd2,
    ST_RUN    = 3'd3,
    ST_STOP   = 3'd4,
    ST_WAITN  = 3'd5
  } pm_state_t;

  typedef struct packed {
    logic clk_en;
    logic osc_en;
    logic pll_en;
    logic pin_hiz;
    logic op_rst;
    logic cpu_halt;
  } pm_ctrl_t;

  function automatic logic pm_is_wait(pm_state_t s);
    return (s == ST_WAITR) || (s == ST_WAITN);
  endfunction

  function automatic pm_ctrl_t pm_decode(pm_state_t s, logic pll_on, logic pll_keep);
    pm_ctrl_t c;
    c.clk_en   = 1'b1;
    c.osc_en   = 1'b1;
    c.pll_en   = pll_on;
    c.pin_hiz  = 1'b0;
    c.op_rst   = 1'b0;
    c.cpu_halt = 1'b1;
    case (s)
      ST_SETRST: c.op_rst = 1'b1;
      ST_WAITR: begin
        c.clk_en = 1'b0;
        c.op_rst = 1'b1;
      end
      ST_OPRST:  c.op_rst = 1'b1;
      ST_RUN:    c.cpu_halt = 1'b0;
      ST_STOP: begin
        c.clk_en  = 1'b0;
        c.osc_en  = 1'b0;
        c.pll_en  = pll_on & pll_keep;
        c.pin_hiz = 1'b1;
      end
      ST_WAITN:  c.clk_en = 1'b0;
      default:   c.op_rst = 1'b1;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pm_stab_timer.sv
module pm_stab_timer #(
  parameter int WAIT_LOG0 = 10,
  parameter int WAIT_LOG1 = 13,
  parameter int WAIT_LOG2 = 15,
  parameter int WAIT_LOG3 = 17,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             done
);
  localparam int MAX01 = (WAIT_LOG0 > WAIT_LOG1) ? WAIT_LOG0 : WAIT_LOG1;
  localparam int MAX23 = (WAIT_LOG2 > WAIT_LOG3) ? WAIT_LOG2 : WAIT_LOG3;
  localparam int MAXL  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int CW    = MAXL + 1;
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] LIM0 = ONE << WAIT_LOG0;
  localparam logic [CW-1:0] LIM1 = ONE << WAIT_LOG1;
  localparam logic [CW-1:0] LIM2 = ONE << WAIT_LOG2;
  localparam logic [CW-1:0] LIM3 = ONE << WAIT_LOG3;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_q;
  logic [CW-1:0] lim_pick;
  logic          done_q;

  always_comb begin
    case (sel)
      2'd0:    lim_pick = LIM0;
      2'd1:    lim_pick = LIM1;
      2'd2:    lim_pick = LIM2;
      default: lim_pick = LIM3;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      lim_q  <= LIM0;
      done_q <= 1'b0;
    end else if (clear) begin
      cnt_q  <= '0;
      lim_q  <= lim_pick;
      done_q <= 1'b0;
    end else if (run) begin
      if (cnt_q != lim_q) cnt_q <= cnt_q + ONE;
      done_q <= (cnt_q == lim_q - ONE);
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done = done_q;

  // R3: expiry pulse only when the count has reached the captured limit
  assert_done_at_limit_R3: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (cnt_q == lim_q));

  // R3: expiry is a single-cycle pulse
  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

endmodule

// File: rtl/pm_state_fsm.sv
module pm_state_fsm
  import pm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      stop_req,
  input  logic      wake,
  input  logic      op_rst_req,
  input  logic      set_rst_req,
  input  logic      wait_done,
  output pm_state_t state_q,
  output pm_state_t state_nxt,
  output logic      tmr_clear,
  output logic      tmr_run,
  output logic      restart_set
);
  pm_state_t st_q, nxt;
  logic      flag_q;

  always_comb begin
    nxt = st_q;
    if (set_rst_req) begin
      nxt = ST_SETRST;
    end else begin
      case (st_q)
        ST_SETRST: nxt = ST_WAITR;
        ST_WAITR:  if (wait_done) nxt = ST_OPRST;
        ST_OPRST:  if (!op_rst_req) nxt = ST_RUN;
        ST_RUN: begin
          if (op_rst_req)    nxt = ST_OPRST;
          else if (stop_req) nxt = ST_STOP;
        end
        ST_STOP: begin
          if (op_rst_req) nxt = ST_WAITR;
          else if (wake)  nxt = ST_WAITN;
        end
        ST_WAITN: begin
          if (op_rst_req)     nxt = ST_WAITR;
          else if (wait_done) nxt = ST_RUN;
        end
        default: nxt = ST_SETRST;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_SETRST;
      flag_q <= 1'b1;
    end else begin
      st_q <= nxt;
      if (nxt == ST_SETRST)
        flag_q <= 1'b1;
      else if (nxt == ST_STOP && st_q != ST_STOP)
        flag_q <= 1'b0;
      else if (st_q == ST_RUN && nxt == ST_OPRST)
        flag_q <= 1'b0;
    end
  end

  assign state_q     = st_q;
  assign state_nxt   = nxt;
  assign tmr_clear   = (nxt != st_q) && pm_is_wait(nxt);
  assign tmr_run     = pm_is_wait(st_q);
  assign restart_set = flag_q;

  // R9: settings reset request wins from every state
  assert_setrst_prio_R9: assert property (@(posedge clk) disable iff (rst)
    set_rst_req |=> (st_q == ST_SETRST));

  // R6: stop is reachable only from run
  assert_stop_from_run_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_STOP) |-> ($past(st_q) == ST_RUN || $past(st_q) == ST_STOP));

  // R4 / R7: run is entered only from operation reset or the run-flavoured wait
  assert_run_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && $past(st_q) != ST_RUN) |->
      ($past(st_q) == ST_OPRST || $past(st_q) == ST_WAITN));

  // R5: restart flag is frozen while running
  assert_flag_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && $past(st_q) == ST_RUN) |-> $stable(flag_q));

endmodule

// File: rtl/pm_out_reg.sv
module pm_out_reg
  import pm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pm_state_t state_nxt,
  input  logic      pll_on,
  input  logic      pll_keep,
  output pm_ctrl_t  ctrl
);
  pm_ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= pm_decode(ST_SETRST, pll_on, pll_keep);
    else     ctrl_q <= pm_decode(state_nxt, pll_on, pll_keep);
  end

  assign ctrl = ctrl_q;

  // R4: release of the operation reset always lands in a clocked, running CPU
  assert_rst_release_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ctrl_q.op_rst) |-> (ctrl_q.clk_en && !ctrl_q.cpu_halt));

  // R6: pins float only after a clocked run cycle
  assert_hiz_entry_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_q.pin_hiz) |-> ($past(ctrl_q.clk_en) && !$past(ctrl_q.cpu_halt)));

endmodule

// File: rtl/pm_state_ctrl.sv
module pm_state_ctrl
  import pm_pkg::*;
#(
  parameter int WAIT_LOG0 = 10,
  parameter int WAIT_LOG1 = 13,
  parameter int WAIT_LOG2 = 15,
  parameter int WAIT_LOG3 = 17
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stop_req,
  input  logic       wake,
  input  logic       op_rst_req,
  input  logic       set_rst_req,
  input  logic [1:0] wait_sel,
  input  logic       pll_on,
  input  logic       pll_keep,
  output logic       clk_en,
  output logic       osc_en,
  output logic       pll_en,
  output logic       pin_hiz,
  output logic       op_rst,
  output logic       cpu_halt,
  output logic       restart_set
);
  localparam int SEL_W = 2;

  pm_state_t st_q, st_nxt;
  logic      tmr_clear, tmr_run, tmr_done;
  pm_ctrl_t  ctrl;

  pm_state_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .stop_req    (stop_req),
    .wake        (wake),
    .op_rst_req  (op_rst_req),
    .set_rst_req (set_rst_req),
    .wait_done   (tmr_done),
    .state_q     (st_q),
    .state_nxt   (st_nxt),
    .tmr_clear   (tmr_clear),
    .tmr_run     (tmr_run),
    .restart_set (restart_set)
  );

  pm_stab_timer #(
    .WAIT_LOG0 (WAIT_LOG0),
    .WAIT_LOG1 (WAIT_LOG1),
    .WAIT_LOG2 (WAIT_LOG2),
    .WAIT_LOG3 (WAIT_LOG3),
    .SEL_W     (SEL_W)
  ) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .clear (tmr_clear),
    .run   (tmr_run),
    .sel   (wait_sel),
    .done  (tmr_done)
  );

  pm_out_reg u_out (
    .clk       (clk),
    .rst       (rst),
    .state_nxt (st_nxt),
    .pll_on    (pll_on),
    .pll_keep  (pll_keep),
    .ctrl      (ctrl)
  );

  assign clk_en   = ctrl.clk_en;
  assign osc_en   = ctrl.osc_en;
  assign pll_en   = ctrl.pll_en;
  assign pin_hiz  = ctrl.pin_hiz;
  assign op_rst   = ctrl.op_rst;
  assign cpu_halt = ctrl.cpu_halt;

  // R2: gated clocks in a wait never coincide with floating pins
  assert_wait_pins_R2: assert property (@(posedge clk) disable iff (rst)
    (pm_is_wait(st_q)) |-> (!pin_hiz && osc_en));

endmodule

// File: tb/sim_pm_state_ctrl.sv
module sim_pm_state_ctrl;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst, stop_req, wake, op_rst_req, set_rst_req, pll_on, pll_keep;
  logic [1:0] wait_sel;
  logic clk_en, osc_en, pll_en, pin_hiz, op_rst, cpu_halt, restart_set;

  int n_chk = 0;
  int n_bad = 0;

  // vector order: clk_en osc_en pll_en pin_hiz op_rst cpu_halt
  localparam logic [5:0] V_SETRST = 6'b111011;
  localparam logic [5:0] V_WAITR  = 6'b011011;
  localparam logic [5:0] V_OPRST  = 6'b111011;
  localparam logic [5:0] V_RUN    = 6'b111000;
  localparam logic [5:0] V_STOP_P = 6'b000101;
  localparam logic [5:0] V_STOP_K = 6'b001101;
  localparam logic [5:0] V_WAITN  = 6'b011001;

  always #(PERIOD/2) clk = ~clk;

  pm_state_ctrl #(.WAIT_LOG0(3), .WAIT_LOG1(4), .WAIT_LOG2(5), .WAIT_LOG3(6)) u0 (
    .clk(clk), .rst(rst), .stop_req(stop_req), .wake(wake),
    .op_rst_req(op_rst_req), .set_rst_req(set_rst_req), .wait_sel(wait_sel),
    .pll_on(pll_on), .pll_keep(pll_keep),
    .clk_en(clk_en), .osc_en(osc_en), .pll_en(pll_en), .pin_hiz(pin_hiz),
    .op_rst(op_rst), .cpu_halt(cpu_halt), .restart_set(restart_set)
  );

  function automatic logic [5:0] vec();
    return {clk_en, osc_en, pll_en, pin_hiz, op_rst, cpu_halt};
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic measure(output int n);
    n = 0;
    while (clk_en == 1'b0 && n < 5000) begin
      n++;
      step(1);
    end
  endtask

  task automatic go_stop();
    stop_req = 1'b1; step(1); stop_req = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; set_rst_req = 1'b1; stop_req = 1'b0; wake = 1'b0;
    op_rst_req = 1'b0; pll_on = 1'b1; pll_keep = 1'b0; wait_sel = 2'd0;
    step(3);
    chk("R1 vector in reset", vec(), V_SETRST);
    rst = 1'b0; step(1);
    chk("R1 vector after reset", vec(), V_SETRST);
    chk("R1 restart flag", restart_set, 1);
  endtask

  task automatic t_init_release();
    int n;
    op_rst_req = 1'b1; set_rst_req = 1'b0; step(1);
    chk("R2 reset wait vector", vec(), V_WAITR);
    measure(n);
    chk("R3 sel0 gated length", n, 9);
    chk("R4 operation reset vector", vec(), V_OPRST);
    step(5);
    chk("R4 held while request high", vec(), V_OPRST);
    op_rst_req = 1'b0; step(1);
    chk("R4 run vector", vec(), V_RUN);
    chk("R5 flag after settings path", restart_set, 1);
  endtask

  task automatic t_stop_wake();
    int n;
    wait_sel = 2'd1; go_stop();
    chk("R6 stop vector no keep", vec(), V_STOP_P);
    chk("R5 flag cleared on stop", restart_set, 0);
    step(3);
    chk("R6 stop holds", vec(), V_STOP_P);
    wake = 1'b1; step(1); wake = 1'b0;
    chk("R7 run wait vector", vec(), V_WAITN);
    measure(n);
    chk("R3 R7 sel1 gated length", n, 17);
    chk("R7 run after wait", vec(), V_RUN);
    chk("R5 flag after stop path", restart_set, 0);
  endtask

  task automatic t_keep_and_latch();
    int n;
    pll_keep = 1'b1; wait_sel = 2'd0; go_stop();
    chk("R6 stop vector with keep", vec(), V_STOP_K);
    wake = 1'b1; step(1); wake = 1'b0; wait_sel = 2'd3;
    measure(n);
    chk("R3 select captured at entry", n, 9);
    pll_keep = 1'b0; wait_sel = 2'd0;
  endtask

  task automatic t_stop_oprst();
    int n;
    go_stop();
    op_rst_req = 1'b1; wake = 1'b1; step(1); wake = 1'b0;
    chk("R8 R10 stop to reset wait", vec(), V_WAITR);
    measure(n);
    chk("R8 reset wait length", n, 9);
    chk("R4 operation reset vector", vec(), V_OPRST);
    op_rst_req = 1'b0; step(1);
    chk("R5 flag op path", restart_set, 0);
  endtask

  task automatic t_waitn_oprst();
    int n;
    go_stop();
    wait_sel = 2'd2; wake = 1'b1; step(1); wake = 1'b0;
    step(5);
    chk("R7 still in run wait", vec(), V_WAITN);
    op_rst_req = 1'b1; step(1);
    chk("R8 run wait to reset wait", vec(), V_WAITR);
    measure(n);
    chk("R8 count restarted", n, 33);
    op_rst_req = 1'b0; step(1);
    chk("R4 run after restart", vec(), V_RUN);
  endtask

  task automatic t_ignore_stop();
    op_rst_req = 1'b1; step(1);
    chk("R8 run to operation reset", vec(), V_OPRST);
    chk("R5 flag cleared run to reset", restart_set, 0);
    stop_req = 1'b1; step(3);
    chk("R6 stop ignored in reset", vec(), V_OPRST);
    stop_req = 1'b0; op_rst_req = 1'b0; step(1);
    chk("R4 run after ignored stop", vec(), V_RUN);
  endtask

  task automatic t_priority();
    int n;
    wait_sel = 2'd0;
    set_rst_req = 1'b1; op_rst_req = 1'b1; stop_req = 1'b1; step(1);
    chk("R9 R10 settings wins in run", vec(), V_SETRST);
    chk("R5 flag set", restart_set, 1);
    set_rst_req = 1'b0; stop_req = 1'b0; step(1);
    chk("R2 exit to reset wait", vec(), V_WAITR);
    step(3);
    set_rst_req = 1'b1; step(1);
    chk("R9 settings from reset wait", vec(), V_SETRST);
    set_rst_req = 1'b0; step(1);
    measure(n);
    chk("R3 wait after settings", n, 9);
    set_rst_req = 1'b1; step(1);
    chk("R9 settings from operation reset", vec(), V_SETRST);
    set_rst_req = 1'b0; op_rst_req = 1'b0; step(1);
    measure(n);
    chk("R4 operation reset one cycle", vec(), V_OPRST);
    step(1);
    chk("R4 run", vec(), V_RUN);
    chk("R5 flag settings path", restart_set, 1);
    go_stop();
    set_rst_req = 1'b1; step(1); set_rst_req = 1'b0;
    chk("R9 settings from stop", vec(), V_SETRST);
  endtask

  task automatic t_sel3();
    int n;
    step(1);
    measure(n);
    step(1);
    go_stop();
    wait_sel = 2'd3; wake = 1'b1; step(1); wake = 1'b0;
    measure(n);
    chk("R3 sel3 gated length", n, 65);
    chk("R7 run after long wait", vec(), V_RUN);
  endtask

  logic finished = 1'b0;

  initial begin
    t_reset();
    t_init_release();
    t_stop_wake();
    t_keep_and_latch();
    t_stop_oprst();
    t_waitn_oprst();
    t_ignore_stop();
    t_priority();
    t_sel3();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule